// File: doc/BRIEF.md
# Configuration Header Clock-Ratio Selector

This block sits beside a 32-bit configuration data stream and watches the beats go by on a valid/data interface without touching them. It counts the accepted words of each stream. From two fixed positions in the stream's header it pulls out whether the image is encrypted and whether it is compressed. It then combines those two flags with the configured data-bus width to pick the clock-to-data ratio code that the configuration engine must use.

Once the second flag word has been seen, the block registers the ratio code, the width flag and both decoded flags, and raises a one-cycle ready strobe. If the stream ends before that word arrives, the header is too short to hold both flags. In that case the block raises a one-cycle error strobe and leaves the previous result untouched. A start-of-stream input restarts the word count for the next image.

Top module: `hdr_ratio_sel`

## Requirements
- R1: After reset, `ratio_o`, `wide_o`, `enc_o` and `cmp_o` are 0, and neither `rdy_o` nor `err_o` is asserted.
- R2: `enc_o` is 1 exactly when bits [3:2] of word 69 (word 0 is the first accepted beat) are not both zero. Other bits of that word have no effect.
- R3: `cmp_o` is the inverse of bit 1 of word 229, so a 0 there means the image is compressed. Other bits of that word have no effect.
- R4: Ratio codes are 0 for x1, 1 for x2, 2 for x4 and 3 for x8. When neither flag is set, `ratio_o` is 0 at both widths.
- R5: With `wide_i` low (16-bit bus), a compressed image gives code 2 and an encrypted-only image gives code 1.
- R6: With `wide_i` high (32-bit bus), each base code is raised by one: a compressed image gives code 3 and an encrypted-only image gives code 2.
- R7: Only cycles with `beat_vld_i` high advance the word count, so idle gaps have no effect. `wide_o` takes the value `wide_i` has on the word-229 beat.
- R8: `rdy_o` is high for exactly one cycle, in the cycle after the word-229 beat is accepted. All four result outputs take their new values in that same cycle.
- R9: If a beat with `beat_last_i` high arrives before word 229, `err_o` pulses for one cycle in the following cycle, `rdy_o` stays low, and the result outputs keep their previous values.
- R10: After a header has been parsed or rejected, further beats have no effect until `sos_i` is asserted. `sos_i` restarts the count, and a valid beat in the same cycle counts as word 0.
- R11: `rdy_o` and `err_o` are never high in the same cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| sos_i | input | 1 | Start of a new stream; clears the word count |
| beat_vld_i | input | 1 | Data beat valid |
| beat_data_i | input | 32 | Data word of the beat |
| beat_last_i | input | 1 | Marks the final beat of the stream |
| wide_i | input | 1 | Bus width: 1 = 32-bit, 0 = 16-bit |
| ratio_o | output | 2 | Selected ratio code (0:x1, 1:x2, 2:x4, 3:x8) |
| wide_o | output | 1 | Width latched with the result |
| enc_o | output | 1 | Decoded encryption flag |
| cmp_o | output | 1 | Decoded compression flag |
| rdy_o | output | 1 | One-cycle strobe: header parsed |
| err_o | output | 1 | One-cycle strobe: stream too short |

## Verification
The bench sweeps all eight combinations of width, encryption and compression. Each of the three nonzero patterns of the two encryption bits appears, and the words carry varying fill bits, so a wrong bit position or polarity shows up as a wrong flag. On non-header beats `wide_i` carries the opposite value, and some streams have idle gaps, which separates correct sampling of the width from sampling at the wrong time, and beat counting from cycle counting. Streams that end after 1, 70 and 229 words test the short-header boundary against the exact 230-word minimum. A second stream sent without a start marker, and a restart in the middle of a stream, test the freeze and restart rules.

// File: rtl/hdr_ratio_pkg.sv
package hdr_ratio_pkg;

  typedef enum logic [1:0] {
    RATIO_X1 = 2'd0,
    RATIO_X2 = 2'd1,
    RATIO_X4 = 2'd2,
    RATIO_X8 = 2'd3
  } ratio_e;

  // Base code from the flags; the 32-bit bus doubles a non-unity ratio.
  function automatic ratio_e pick_ratio(logic wide, logic enc, logic cmp);
    logic [1:0] base;
    if (!enc && !cmp) return RATIO_X1;
    base = cmp ? 2'd2 : 2'd1;
    return ratio_e'(base + {1'b0, wide});
  endfunction

endpackage

// File: rtl/hdr_word_ctr.sv
module hdr_word_ctr #(
  parameter int LAST_IDX = 229,
  localparam int CNT_W = $clog2(LAST_IDX + 1)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             sos_i,
  input  logic             vld_i,
  input  logic             last_i,
  output logic [CNT_W-1:0] idx_o,
  output logic             acc_o,
  output logic             hit_o,
  output logic             short_o
);
  logic [CNT_W-1:0] cnt_q;
  logic             done_q;
  logic             live;

  assign idx_o   = sos_i ? '0 : cnt_q;
  assign live    = sos_i || !done_q;
  assign acc_o   = vld_i && live;
  assign hit_o   = acc_o && (idx_o == CNT_W'(LAST_IDX));
  assign short_o = acc_o && last_i && !hit_o;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      cnt_q  <= '0;
      done_q <= 1'b0;
    end else begin
      if (sos_i) begin
        cnt_q  <= '0;
        done_q <= 1'b0;
      end
      if (acc_o) begin
        if (hit_o || short_o) done_q <= 1'b1;
        else                  cnt_q  <= idx_o + CNT_W'(1);
      end
    end
  end

  // R10
  ctr_frozen_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (done_q && !sos_i) |=> $stable(cnt_q));

  // R7
  ctr_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
    cnt_q <= CNT_W'(LAST_IDX));

endmodule

// File: rtl/hdr_flag_cap.sv
module hdr_flag_cap #(
  parameter int WORD_W  = 32,
  parameter int ENC_IDX = 69,
  parameter int ENC_LSB = 2,
  parameter int CMP_BIT = 1,
  parameter int IDX_W   = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              sos_i,
  input  logic              acc_i,
  input  logic [IDX_W-1:0]  idx_i,
  input  logic [WORD_W-1:0] data_i,
  output logic              enc_o,
  output logic              cmp_now_o
);
  logic enc_q;
  logic enc_beat;

  assign enc_beat  = acc_i && (idx_i == IDX_W'(ENC_IDX));
  assign enc_o     = enc_q;
  assign cmp_now_o = ~data_i[CMP_BIT];

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      enc_q <= 1'b0;
    end else begin
      if (sos_i)    enc_q <= 1'b0;
      if (enc_beat) enc_q <= |data_i[ENC_LSB +: 2];
    end
  end

  // R2
  enc_load_chk: assert property (@(posedge clk) disable iff (!rst_n)
    enc_beat |=> (enc_q == |$past(data_i[ENC_LSB +: 2])));

endmodule

// File: rtl/hdr_ratio_map.sv
module hdr_ratio_map
  import hdr_ratio_pkg::*;
(
  input  logic       wide_i,
  input  logic       enc_i,
  input  logic       cmp_i,
  output logic [1:0] code_o
);
  ratio_e sel;

  always_comb begin
    sel    = pick_ratio(wide_i, enc_i, cmp_i);
    code_o = sel;
  end

  // R4
  always_comb begin
    x1_map_chk: assert (!(enc_i || cmp_i) -> (code_o == 2'd0));
  end

endmodule

// File: rtl/hdr_ratio_sel.sv
module hdr_ratio_sel #(
  parameter int WORD_W  = 32,
  parameter int ENC_IDX = 69,
  parameter int ENC_LSB = 2,
  parameter int CMP_IDX = 229,
  parameter int CMP_BIT = 1,
  localparam int IDX_W  = $clog2(CMP_IDX + 1)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              sos_i,
  input  logic              beat_vld_i,
  input  logic [WORD_W-1:0] beat_data_i,
  input  logic              beat_last_i,
  input  logic              wide_i,
  output logic [1:0]        ratio_o,
  output logic              wide_o,
  output logic              enc_o,
  output logic              cmp_o,
  output logic              rdy_o,
  output logic              err_o
);
  logic [IDX_W-1:0] idx;
  logic             acc;
  logic             hit;
  logic             short_hdr;
  logic             enc_flag;
  logic             cmp_now;
  logic [1:0]       code_now;

  hdr_word_ctr #(.LAST_IDX(CMP_IDX)) ctr_i (
    .clk(clk), .rst_n(rst_n), .sos_i(sos_i), .vld_i(beat_vld_i),
    .last_i(beat_last_i), .idx_o(idx), .acc_o(acc), .hit_o(hit),
    .short_o(short_hdr)
  );

  hdr_flag_cap #(
    .WORD_W(WORD_W), .ENC_IDX(ENC_IDX), .ENC_LSB(ENC_LSB),
    .CMP_BIT(CMP_BIT), .IDX_W(IDX_W)
  ) cap_i (
    .clk(clk), .rst_n(rst_n), .sos_i(sos_i), .acc_i(acc), .idx_i(idx),
    .data_i(beat_data_i), .enc_o(enc_flag), .cmp_now_o(cmp_now)
  );

  hdr_ratio_map map_i (
    .wide_i(wide_i), .enc_i(enc_flag), .cmp_i(cmp_now), .code_o(code_now)
  );

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      ratio_o <= 2'd0;
      wide_o  <= 1'b0;
      enc_o   <= 1'b0;
      cmp_o   <= 1'b0;
      rdy_o   <= 1'b0;
      err_o   <= 1'b0;
    end else begin
      rdy_o <= hit;
      err_o <= short_hdr;
      if (hit) begin
        ratio_o <= code_now;
        wide_o  <= wide_i;
        enc_o   <= enc_flag;
        cmp_o   <= cmp_now;
      end
    end
  end

  // R11
  strobe_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !(rdy_o && err_o));

  // R8
  rdy_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
    rdy_o |=> !rdy_o);

  // R4
  x1_code_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (rdy_o && !enc_o && !cmp_o) |-> (ratio_o == 2'd0));

  // R6
  cmp_code_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (rdy_o && cmp_o) |-> (ratio_o == {1'b1, wide_o}));

  // R9
  err_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    err_o |-> $stable(ratio_o));

endmodule

// File: tb/hdr_ratio_sel_tb.sv
module hdr_ratio_sel_tb_top;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        sos_i = 1'b0;
  logic        beat_vld_i = 1'b0;
  logic [31:0] beat_data_i = '0;
  logic        beat_last_i = 1'b0;
  logic        wide_i = 1'b0;
  logic [1:0]  ratio_o;
  logic        wide_o, enc_o, cmp_o, rdy_o, err_o;

  int n_chk = 0;
  int n_bad = 0;
  int rdy_cnt, err_cnt, rdy_at, err_at;
  bit done_flag = 1'b0;

  always #5ns clk = ~clk;

  hdr_ratio_sel dut_i (
    .clk(clk), .rst_n(rst_n), .sos_i(sos_i), .beat_vld_i(beat_vld_i),
    .beat_data_i(beat_data_i), .beat_last_i(beat_last_i), .wide_i(wide_i),
    .ratio_o(ratio_o), .wide_o(wide_o), .enc_o(enc_o), .cmp_o(cmp_o),
    .rdy_o(rdy_o), .err_o(err_o)
  );

  task automatic chk(bit ok, string req, string what, int act, int exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
    end
  endtask

  function automatic logic [31:0] fill(int i, int seed);
    return (i * 32'h9E3779B9) ^ (seed * 32'h85EBCA6B) ^ 32'h5A5A3C3C;
  endfunction

  // Expected ratio code as log2 of the clock multiplier.
  function automatic int exp_code(bit w, bit enc, bit cmp);
    int mult;
    if (!enc && !cmp) mult = 1;
    else begin
      mult = cmp ? 4 : 2;
      if (w) mult = mult * 2;
    end
    return $clog2(mult);
  endfunction

  task automatic sample(int prev);
    if (rdy_o) begin rdy_cnt++; rdy_at = prev; end
    if (err_o) begin err_cnt++; err_at = prev; end
  endtask

  // Sends n beats; the strobes are sampled one cycle after each beat.
  task automatic stream(int n, bit w, bit [1:0] eb, bit cb, int gap,
                        int seed, bit with_last, bit with_sos);
    logic [31:0] d;
    int prev = -1;
    rdy_cnt = 0; err_cnt = 0; rdy_at = -1; err_at = -1;
    for (int i = 0; i < n; i++) begin
      @(negedge clk);
      if (prev >= 0) sample(prev);
      if (gap > 0 && i > 0 && (i % gap) == 0) begin
        beat_vld_i = 1'b0; sos_i = 1'b0; beat_last_i = 1'b0;
        wide_i = w;
        @(negedge clk);
        sample(prev);
      end
      d = fill(i, seed);
      if (i == 69)  d[3:2] = eb;
      if (i == 229) d[1]   = cb;
      beat_data_i = d;
      beat_vld_i  = 1'b1;
      sos_i       = with_sos && (i == 0);
      beat_last_i = with_last && (i == n - 1);
      wide_i      = (i == 229) ? w : ~w;
      prev = i;
    end
    @(negedge clk);
    sample(prev);
    beat_vld_i = 1'b0; sos_i = 1'b0; beat_last_i = 1'b0;
    @(negedge clk);
    sample(-2);
  endtask

  task automatic full_case(bit w, bit [1:0] eb, bit cb, int gap, int seed);
    bit enc, cmp;
    enc = (eb != 2'b00);
    cmp = ~cb;
    stream(230, w, eb, cb, gap, seed, 1'b1, 1'b1);
    chk(rdy_cnt == 1 && rdy_at == 229, "R8", "ready strobe at word 229",
        rdy_at, 229);
    chk(err_cnt == 0, "R11", "no error on full header", err_cnt, 0);
    chk(enc_o == enc, "R2", "encryption flag", enc_o, enc);
    chk(cmp_o == cmp, "R3", "compression flag", cmp_o, cmp);
    chk(wide_o == w, "R7", "latched width", wide_o, w);
    if (!enc && !cmp)
      chk(ratio_o == exp_code(w, enc, cmp), "R4", "x1 code", ratio_o,
          exp_code(w, enc, cmp));
    else if (!w)
      chk(ratio_o == exp_code(w, enc, cmp), "R5", "16-bit code", ratio_o,
          exp_code(w, enc, cmp));
    else
      chk(ratio_o == exp_code(w, enc, cmp), "R6", "32-bit code", ratio_o,
          exp_code(w, enc, cmp));
  endtask

  task automatic short_case(int n, int seed);
    logic [1:0] r0;
    logic e0, c0, w0;
    r0 = ratio_o; e0 = enc_o; c0 = cmp_o; w0 = wide_o;
    stream(n, 1'b1, 2'b11, 1'b0, 0, seed, 1'b1, 1'b1);
    chk(err_cnt == 1 && err_at == n - 1, "R9", "error strobe after last",
        err_at, n - 1);
    chk(rdy_cnt == 0, "R9", "no ready on short stream", rdy_cnt, 0);
    chk(ratio_o == r0 && enc_o == e0 && cmp_o == c0 && wide_o == w0, "R9",
        "results held", ratio_o, r0);
  endtask

  initial begin
    #2ms;
    n_bad++; n_chk++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    chk(ratio_o == 0 && wide_o == 0 && enc_o == 0 && cmp_o == 0, "R1",
        "reset results", ratio_o, 0);
    chk(!rdy_o && !err_o, "R1", "reset strobes", rdy_o + err_o, 0);
    rst_n = 1'b1;

    // R2 R3 R4 R5 R6: sweep width, encryption pattern and compression bit
    for (int w = 0; w < 2; w++)
      for (int e = 0; e < 4; e++)
        for (int c = 0; c < 2; c++)
          full_case(w[0], e[1:0], c[0], (e == 2) ? 7 : 0, w * 8 + e * 2 + c);

    // R7: idle gaps between beats
    full_case(1'b1, 2'b01, 1'b1, 3, 41);
    full_case(1'b0, 2'b00, 1'b0, 5, 42);

    // R9: stream ends too early, including one short of the minimum
    full_case(1'b1, 2'b10, 1'b1, 0, 50);
    short_case(1, 51);
    short_case(70, 52);
    short_case(229, 53);

    // R10: beats after a parsed header without a restart are ignored
    full_case(1'b0, 2'b11, 1'b1, 0, 60);
    stream(240, 1'b1, 2'b00, 1'b0, 0, 61, 1'b1, 1'b0);
    chk(rdy_cnt == 0 && err_cnt == 0, "R10", "no strobe without restart",
        rdy_cnt + err_cnt, 0);
    chk(ratio_o == 1 && enc_o == 1 && cmp_o == 0 && wide_o == 0, "R10",
        "results unchanged without restart", ratio_o, 1);

    // R10: restart in the middle of a stream
    stream(100, 1'b0, 2'b00, 1'b0, 0, 62, 1'b0, 1'b1);
    chk(rdy_cnt == 0 && err_cnt == 0, "R10", "partial stream no strobe",
        rdy_cnt + err_cnt, 0);
    full_case(1'b1, 2'b00, 1'b0, 0, 63);

    done_flag = 1'b1;
    $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
    $finish;
  end

  // R11: strobes never coincide
  always @(negedge clk) begin
    if (rst_n && !done_flag && rdy_o && err_o)
      chk(1'b0, "R11", "both strobes high", 1, 0);
  end

endmodule